// File: doc/BRIEF.md
# Queue Doorbell Write Handler

This block sits behind the register decoder of a host-facing storage controller and turns host writes into a doorbell window into pointer updates for a set of paired submission and completion queues. Each queue pair owns one 8-byte slot in the window. The lower 32-bit word of the slot carries the new submission-queue tail. The upper word carries the new completion-queue head. Only the low pointer-width bits of the written data are used.

Every write is checked before it is applied. A queue id that does not name an existing queue, or a pointer that does not fit the queue size, discards the write and raises an error event request with its own code. A valid completion-head write can raise an interrupt request for its queue and a clear request for the pending bit of its interrupt vector. Both kinds of valid write can arm a single shared countdown that later prompts submission processing. Queue sizes, validity, vectors, interrupt enables and completion tails are supplied by the surrounding logic. All pulses are registered and appear in the cycle after the write.

Top module: `dbell_write_handler`

## Requirements
- R1: The word index is (wr_addr − BASE) / 4 and the queue id is (wr_addr − BASE) / 8. An even word index writes the submission tail of that queue and an odd word index writes the completion head. A write with wr_addr below BASE has no effect at all.
- R2: Only wr_data[IDX_W-1:0] is taken as the new pointer. The upper data bits never affect checking or the stored value.
- R3: A queue id ≥ NUM_Q, or one whose valid bit is clear for the addressed queue type, discards the write and pulses evt_req_o with evt_code_o = 1 for both queue types. When evt_req_o is low, evt_code_o is 0.
- R4: For an existing queue, a new pointer ≥ that queue's size discards the write and pulses evt_req_o with evt_code_o = 2.
- R5: An accepted write updates its pointer, and the value is visible on sq_tail_o or cq_head_o one cycle after the write. evt_req_o, irq_req_o and pend_clr_o are single-cycle pulses that are only raised in the cycle after a write. Pointers never change without a write.
- R6: On an accepted completion-head write, if (tail + 1) mod size equalled the old head, the timer is armed with the full delay, even when it is already running.
- R7: After an accepted completion-head write, pend_clr_o pulses with pend_vec_o = that queue's vector if its interrupts are enabled and every valid completion queue on that vector has tail equal to head, using the new head.
- R8: After an accepted completion-head write, irq_req_o pulses with irq_qid_o = the queue id when the queue's tail differs from the new head.
- R9: An accepted submission-tail write arms the timer only when it is idle. A running timer keeps its count.
- R10: Once armed, the timer raises tmr_expire_o for exactly one cycle DELAY_CYC cycles after the arming write is taken, and tmr_armed_o falls in that same cycle.
- R11: After reset, all pointers are 0, no pulse is raised and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| sq_size_i | input | NUM_Q*IDX_W | Submission queue sizes in entries |
| sq_valid_i | input | NUM_Q | Submission queue exists |
| cq_size_i | input | NUM_Q*IDX_W | Completion queue sizes in entries |
| cq_valid_i | input | NUM_Q | Completion queue exists |
| cq_vec_i | input | NUM_Q*VEC_W | Interrupt vector of each completion queue |
| cq_irq_en_i | input | NUM_Q | Interrupts enabled per completion queue |
| cq_tail_i | input | NUM_Q*IDX_W | Completion queue tails |
| sq_tail_o | output | NUM_Q*IDX_W | Stored submission tails |
| cq_head_o | output | NUM_Q*IDX_W | Stored completion heads |
| evt_req_o | output | 1 | Error event request pulse |
| evt_code_o | output | 2 | 1 = bad queue id, 2 = bad pointer value |
| irq_req_o | output | 1 | Interrupt request pulse |
| irq_qid_o | output | QID_W | Queue id for the interrupt request |
| pend_clr_o | output | 1 | Pending-bit clear pulse |
| pend_vec_o | output | VEC_W | Vector whose pending bit is cleared |
| tmr_armed_o | output | 1 | Processing timer running |
| tmr_expire_o | output | 1 | Processing timer expiry pulse |

## Verification
Both doorbell types are swept over every queue id up to one beyond the last, and every pointer value up to two beyond the largest size. This separates the bad-id code from the bad-value code, and it also separates a missing queue from an existing one whose valid bit is clear. Completion pointers are written in descending order, so that the old head sometimes sits one past the tail. This exercises the full-queue re-arm, and the fixed tails make the interrupt and pending-clear decisions differ from queue to queue. Directed timer runs then show that a second submission write leaves a running count alone while a drain of a full queue restarts it. Writes below the window and upper data bits are also shown to leave state unchanged.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    typedef enum logic [1:0] {
        EVT_NONE    = 2'd0,
        EVT_BAD_QID = 2'd1,
        EVT_BAD_VAL = 2'd2
    } evt_code_e;

    typedef enum logic [1:0] {
        DB_NONE = 2'd0,
        DB_SQ   = 2'd1,
        DB_CQ   = 2'd2
    } db_kind_e;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_Q  = 4,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter int QID_W  = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output db_kind_e          kind,
    output logic [QID_W-1:0]  qid,
    output logic              qid_ok
);
    localparam int SLOT_W = ADDR_W - 3;

    logic [ADDR_W-1:0] offset;
    logic [SLOT_W-1:0] slot;
    logic              below;
    logic              addr_lo_unused;

    assign below          = (wr_addr < BASE);
    assign offset         = wr_addr - BASE;
    // one 8-byte slot per queue pair: lower word SQ tail, upper word CQ head
    assign slot           = offset[ADDR_W-1:3];
    assign addr_lo_unused = ^offset[1:0];
    assign qid            = slot[QID_W-1:0];
    assign qid_ok         = (slot < SLOT_W'(NUM_Q));

    always_comb begin
        kind = DB_NONE;
        if (wr_en && !below) begin
            kind = offset[2] ? DB_CQ : DB_SQ;
        end
    end

endmodule

// File: rtl/dbell_cq_eval.sv
module dbell_cq_eval #(
    parameter int NUM_Q = 4,
    parameter int IDX_W = 16,
    parameter int VEC_W = 2,
    parameter int QID_W = 2
) (
    input  logic [QID_W-1:0]             qid,
    input  logic [IDX_W-1:0]             new_head,
    input  logic [NUM_Q-1:0][IDX_W-1:0]  head_cur,
    input  logic [NUM_Q-1:0][IDX_W-1:0]  tail,
    input  logic [NUM_Q-1:0][IDX_W-1:0]  size,
    input  logic [NUM_Q-1:0]             valid,
    input  logic [NUM_Q-1:0]             irq_en,
    input  logic [NUM_Q-1:0][VEC_W-1:0]  vec,
    output logic                         was_full,
    output logic                         tail_ne_head,
    output logic                         vec_empty,
    output logic                         sel_irq_en,
    output logic [VEC_W-1:0]             sel_vec
);
    logic [IDX_W:0]     tail_inc;
    logic [IDX_W-1:0]   tail_wrap;
    logic [NUM_Q-1:0]   q_quiet;

    assign sel_vec    = vec[qid];
    assign sel_irq_en = irq_en[qid];
    assign tail_inc   = {1'b0, tail[qid]} + 1'b1;

    always_comb begin
        if (tail_inc >= {1'b0, size[qid]}) begin
            tail_wrap = '0;
        end else begin
            tail_wrap = tail_inc[IDX_W-1:0];
        end
    end

    assign was_full     = (tail_wrap == head_cur[qid]);
    assign tail_ne_head = (tail[qid] != new_head);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_quiet
        logic [IDX_W-1:0] hd;
        assign hd = (QID_W'(g) == qid) ? new_head : head_cur[g];
        assign q_quiet[g] = !valid[g] || (vec[g] != sel_vec) || (tail[g] == hd);
    end

    assign vec_empty = &q_quiet;

endmodule

// File: rtl/dbell_timer.sv
module dbell_timer #(
    parameter int DELAY_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_force,
    input  logic arm_if_idle,
    output logic armed,
    output logic expire
);
    localparam int CNT_W = $clog2(DELAY_CYC + 1);

    typedef struct packed {
        logic             armed;
        logic             expire;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (arm_force || (arm_if_idle && !st_q.armed)) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CNT_W'(DELAY_CYC);
        end else if (st_q.armed) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.armed  = 1'b0;
                st_d.expire = 1'b1;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed  = st_q.armed;
    assign expire = st_q.expire;

endmodule

// File: rtl/dbell_write_handler.sv
module dbell_write_handler
    import dbell_pkg::*;
#(
    parameter int NUM_Q     = 4,
    parameter int IDX_W     = 16,
    parameter int VEC_W     = 2,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h1000,
    parameter int DELAY_CYC = 1000,
    localparam int QID_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [NUM_Q*IDX_W-1:0] sq_size_i,
    input  logic [NUM_Q-1:0]       sq_valid_i,
    input  logic [NUM_Q*IDX_W-1:0] cq_size_i,
    input  logic [NUM_Q-1:0]       cq_valid_i,
    input  logic [NUM_Q*VEC_W-1:0] cq_vec_i,
    input  logic [NUM_Q-1:0]       cq_irq_en_i,
    input  logic [NUM_Q*IDX_W-1:0] cq_tail_i,
    output logic [NUM_Q*IDX_W-1:0] sq_tail_o,
    output logic [NUM_Q*IDX_W-1:0] cq_head_o,
    output logic                   evt_req_o,
    output logic [1:0]             evt_code_o,
    output logic                   irq_req_o,
    output logic [QID_W-1:0]       irq_qid_o,
    output logic                   pend_clr_o,
    output logic [VEC_W-1:0]       pend_vec_o,
    output logic                   tmr_armed_o,
    output logic                   tmr_expire_o
);
    typedef struct packed {
        logic [NUM_Q-1:0][IDX_W-1:0] sq_tail;
        logic [NUM_Q-1:0][IDX_W-1:0] cq_head;
        logic                        evt_req;
        evt_code_e                   evt_code;
        logic                        irq_req;
        logic [QID_W-1:0]            irq_qid;
        logic                        pend_clr;
        logic [VEC_W-1:0]            pend_vec;
    } hdl_t;

    hdl_t st_d, st_q;

    logic [NUM_Q-1:0][IDX_W-1:0] sq_size_a, cq_size_a, cq_tail_a;
    logic [NUM_Q-1:0][VEC_W-1:0] cq_vec_a;

    assign sq_size_a = sq_size_i;
    assign cq_size_a = cq_size_i;
    assign cq_tail_a = cq_tail_i;
    assign cq_vec_a  = cq_vec_i;

    db_kind_e         kind;
    logic [QID_W-1:0] qid;
    logic             qid_ok;
    logic [IDX_W-1:0] new_ptr;
    logic             data_hi_unused;

    assign new_ptr        = wr_data[IDX_W-1:0];
    assign data_hi_unused = ^wr_data[31:IDX_W];

    dbell_decode #(
        .ADDR_W (ADDR_W),
        .NUM_Q  (NUM_Q),
        .BASE   (BASE),
        .QID_W  (QID_W)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .kind    (kind),
        .qid     (qid),
        .qid_ok  (qid_ok)
    );

    logic             cq_was_full;
    logic             cq_pending;
    logic             cq_vec_empty;
    logic             cq_sel_irq_en;
    logic [VEC_W-1:0] cq_sel_vec;

    dbell_cq_eval #(
        .NUM_Q (NUM_Q),
        .IDX_W (IDX_W),
        .VEC_W (VEC_W),
        .QID_W (QID_W)
    ) u_cq (
        .qid          (qid),
        .new_head     (new_ptr),
        .head_cur     (st_q.cq_head),
        .tail         (cq_tail_a),
        .size         (cq_size_a),
        .valid        (cq_valid_i),
        .irq_en       (cq_irq_en_i),
        .vec          (cq_vec_a),
        .was_full     (cq_was_full),
        .tail_ne_head (cq_pending),
        .vec_empty    (cq_vec_empty),
        .sel_irq_en   (cq_sel_irq_en),
        .sel_vec      (cq_sel_vec)
    );

    logic arm_force, arm_if_idle;

    always_comb begin
        st_d          = st_q;
        st_d.evt_req  = 1'b0;
        st_d.evt_code = EVT_NONE;
        st_d.irq_req  = 1'b0;
        st_d.irq_qid  = '0;
        st_d.pend_clr = 1'b0;
        st_d.pend_vec = '0;
        arm_force     = 1'b0;
        arm_if_idle   = 1'b0;

        unique case (kind)
            DB_SQ: begin
                if (!qid_ok || !sq_valid_i[qid]) begin
                    st_d.evt_req  = 1'b1;
                    st_d.evt_code = EVT_BAD_QID;
                end else if (new_ptr >= sq_size_a[qid]) begin
                    st_d.evt_req  = 1'b1;
                    st_d.evt_code = EVT_BAD_VAL;
                end else begin
                    st_d.sq_tail[qid] = new_ptr;
                    arm_if_idle       = 1'b1;
                end
            end
            DB_CQ: begin
                if (!qid_ok || !cq_valid_i[qid]) begin
                    st_d.evt_req  = 1'b1;
                    st_d.evt_code = EVT_BAD_QID;
                end else if (new_ptr >= cq_size_a[qid]) begin
                    st_d.evt_req  = 1'b1;
                    st_d.evt_code = EVT_BAD_VAL;
                end else begin
                    st_d.cq_head[qid] = new_ptr;
                    arm_force         = cq_was_full;
                    if (cq_pending) begin
                        st_d.irq_req = 1'b1;
                        st_d.irq_qid = qid;
                    end
                    if (cq_sel_irq_en && cq_vec_empty) begin
                        st_d.pend_clr = 1'b1;
                        st_d.pend_vec = cq_sel_vec;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dbell_timer #(
        .DELAY_CYC (DELAY_CYC)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_force   (arm_force),
        .arm_if_idle (arm_if_idle),
        .armed       (tmr_armed_o),
        .expire      (tmr_expire_o)
    );

    assign sq_tail_o  = st_q.sq_tail;
    assign cq_head_o  = st_q.cq_head;
    assign evt_req_o  = st_q.evt_req;
    assign evt_code_o = st_q.evt_code;
    assign irq_req_o  = st_q.irq_req;
    assign irq_qid_o  = st_q.irq_qid;
    assign pend_clr_o = st_q.pend_clr;
    assign pend_vec_o = st_q.pend_vec;

endmodule

// File: rtl/dbell_write_handler_chk.sv
module dbell_write_handler_chk #(
    parameter int NUM_Q = 4,
    parameter int IDX_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [NUM_Q*IDX_W-1:0] sq_tail_o,
    input logic [NUM_Q*IDX_W-1:0] cq_head_o,
    input logic                   evt_req_o,
    input logic [1:0]             evt_code_o,
    input logic                   irq_req_o,
    input logic                   pend_clr_o,
    input logic                   tmr_armed_o,
    input logic                   tmr_expire_o
);

    // R3: an event carries one of the two known codes
    a_r3_evt_code_known: assert property (@(posedge clk) disable iff (!rst_n)
        evt_req_o |-> (evt_code_o == 2'd1 || evt_code_o == 2'd2));

    // R3: code bus idles at zero
    a_r3_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_req_o |-> (evt_code_o == 2'd0));

    // R5: pulses only follow a write
    a_r5_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_req_o || irq_req_o || pend_clr_o) |-> $past(wr_en));

    // R5: a rejected write raises no queue side effect
    a_r5_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        evt_req_o |-> (!irq_req_o && !pend_clr_o));

    // R5: pointers hold without a write
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(sq_tail_o) && $stable(cq_head_o)));

    // R9: the timer only starts because of a write
    a_r9_arm_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_armed_o) |-> $past(wr_en));

    // R10: expiry ends a running count and disarms
    a_r10_expire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire_o |-> (!tmr_armed_o && $past(tmr_armed_o)));

    // R10: expiry is a single-cycle pulse
    a_r10_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire_o |=> !tmr_expire_o);

endmodule

bind dbell_write_handler dbell_write_handler_chk #(
    .NUM_Q (NUM_Q),
    .IDX_W (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .sq_tail_o    (sq_tail_o),
    .cq_head_o    (cq_head_o),
    .evt_req_o    (evt_req_o),
    .evt_code_o   (evt_code_o),
    .irq_req_o    (irq_req_o),
    .pend_clr_o   (pend_clr_o),
    .tmr_armed_o  (tmr_armed_o),
    .tmr_expire_o (tmr_expire_o)
);

// File: tb/dbell_write_handler_test.sv
`timescale 1ns/1ps
module dbell_write_handler_test;
    localparam int NQ = 4;
    localparam int IW = 16;
    localparam int VW = 2;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h1000;
    localparam int D  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [NQ*IW-1:0] sq_size, cq_size, cq_tail;
    logic [NQ-1:0] sq_valid, cq_valid, cq_irq_en;
    logic [NQ*VW-1:0] cq_vec;
    logic [NQ*IW-1:0] sq_tail_o, cq_head_o;
    logic evt_req_o, irq_req_o, pend_clr_o, tmr_armed_o, tmr_expire_o;
    logic [1:0] evt_code_o;
    logic [1:0] irq_qid_o;
    logic [VW-1:0] pend_vec_o;

    int n_tests = 0;
    int n_fail  = 0;
    int m_sq [NQ];
    int m_cq [NQ];
    int tails [NQ] = '{2, 0, 5, 1};
    int vecs  [NQ] = '{0, 0, 1, 1};

    always #2.5 clk = ~clk;

    dbell_write_handler #(
        .NUM_Q(NQ), .IDX_W(IW), .VEC_W(VW), .ADDR_W(AW),
        .BASE(BASE), .DELAY_CYC(D)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sq_size_i(sq_size), .sq_valid_i(sq_valid),
        .cq_size_i(cq_size), .cq_valid_i(cq_valid), .cq_vec_i(cq_vec),
        .cq_irq_en_i(cq_irq_en), .cq_tail_i(cq_tail),
        .sq_tail_o(sq_tail_o), .cq_head_o(cq_head_o),
        .evt_req_o(evt_req_o), .evt_code_o(evt_code_o),
        .irq_req_o(irq_req_o), .irq_qid_o(irq_qid_o),
        .pend_clr_o(pend_clr_o), .pend_vec_o(pend_vec_o),
        .tmr_armed_o(tmr_armed_o), .tmr_expire_o(tmr_expire_o)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at a falling edge; write is taken at the next rising edge,
    // returns at the falling edge right after it
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int sqsz(int q); return 3 + q; endfunction
    function automatic int cqsz(int q); return 4 + q; endfunction
    function automatic int rd_sq(int q); return int'(sq_tail_o[q*IW +: IW]); endfunction
    function automatic int rd_cq(int q); return int'(cq_head_o[q*IW +: IW]); endfunction

    initial begin
        for (int q = 0; q < NQ; q++) begin
            sq_size[q*IW +: IW] = IW'(sqsz(q));
            cq_size[q*IW +: IW] = IW'(cqsz(q));
            cq_tail[q*IW +: IW] = IW'(tails[q]);
            cq_vec[q*VW +: VW]  = VW'(vecs[q]);
            m_sq[q] = 0;
            m_cq[q] = 0;
        end
        sq_valid  = 4'b1011;
        cq_valid  = 4'b0111;
        cq_irq_en = 4'b1101;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", "sq_tail", longint'(sq_tail_o), 0);
        chk("R11", "cq_head", longint'(cq_head_o), 0);
        chk("R11", "evt_req", evt_req_o, 0);
        chk("R11", "irq_req", irq_req_o, 0);
        chk("R11", "pend_clr", pend_clr_o, 0);
        chk("R11", "tmr_armed", tmr_armed_o, 0);

        // SQ sweep: R1 R2 R3 R4 R5 R9
        for (int q = 0; q <= NQ; q++) begin
            for (int v = 0; v <= 8; v++) begin
                bit ok_id;
                ok_id = (q < NQ) && sq_valid[q % NQ];
                do_write(BASE + AW'(q * 8), {16'hBEEF, 16'(v)});
                if (!ok_id) begin
                    chk("R3", "sq evt_req", evt_req_o, 1);
                    chk("R3", "sq evt_code", evt_code_o, 1);
                end else if (v >= sqsz(q)) begin
                    chk("R4", "sq evt_req", evt_req_o, 1);
                    chk("R4", "sq evt_code", evt_code_o, 2);
                end else begin
                    m_sq[q] = v;
                    chk("R3", "sq evt_code idle", evt_code_o, 0);
                    chk("R9", "sq arms idle timer", tmr_armed_o, 1);
                end
                for (int p = 0; p < NQ; p++) chk("R1 R2 R5", "sq_tail", rd_sq(p), m_sq[p]);
                chk("R1", "cq_head untouched by sq", longint'(cq_head_o), 0);
                repeat (D + 2) @(negedge clk);
            end
        end

        // CQ sweep (descending pointers reach the full condition): R1 R3 R4 R6 R7 R8
        for (int q = 0; q <= NQ; q++) begin
            for (int v = 8; v >= 0; v--) begin
                bit ok_id, full, empty_all;
                ok_id = (q < NQ) && cq_valid[q % NQ];
                do_write(BASE + 16'd4 + AW'(q * 8), {16'h5A5A, 16'(v)});
                if (!ok_id) begin
                    chk("R3", "cq evt_req", evt_req_o, 1);
                    chk("R3", "cq evt_code", evt_code_o, 1);
                    chk("R3", "cq no irq", irq_req_o, 0);
                end else if (v >= cqsz(q)) begin
                    chk("R4", "cq evt_req", evt_req_o, 1);
                    chk("R4", "cq evt_code", evt_code_o, 2);
                    chk("R4", "cq no pend", pend_clr_o, 0);
                end else begin
                    full = (((tails[q] + 1) % cqsz(q)) == m_cq[q]);
                    m_cq[q] = v;
                    empty_all = 1'b1;
                    for (int p = 0; p < NQ; p++)
                        if (cq_valid[p] && vecs[p] == vecs[q] && tails[p] != m_cq[p])
                            empty_all = 1'b0;
                    chk("R5", "cq evt_req", evt_req_o, 0);
                    chk("R8", "irq_req", irq_req_o, (tails[q] != v));
                    if (tails[q] != v) chk("R8", "irq_qid", irq_qid_o, q);
                    chk("R7", "pend_clr", pend_clr_o, cq_irq_en[q] && empty_all);
                    if (cq_irq_en[q] && empty_all) chk("R7", "pend_vec", pend_vec_o, vecs[q]);
                    chk("R6", "full arms timer", tmr_armed_o, full);
                end
                for (int p = 0; p < NQ; p++) chk("R1 R5", "cq_head", rd_cq(p), m_cq[p]);
                @(negedge clk);
                chk("R5", "pulses drop", {evt_req_o, irq_req_o, pend_clr_o}, 0);
                repeat (D + 1) @(negedge clk);
            end
        end

        // R1: write below the window has no effect
        do_write(BASE - 16'd4, 32'd1);
        chk("R1", "below base evt", evt_req_o, 0);
        chk("R1", "below base armed", tmr_armed_o, 0);
        for (int p = 0; p < NQ; p++) chk("R1", "below base sq_tail", rd_sq(p), m_sq[p]);

        // R9 R10: second SQ write leaves running timer alone
        do_write(BASE, 32'd1);                 // arm edge E0
        repeat (3) @(negedge clk);             // after E3
        do_write(BASE, 32'd2);                 // taken at E4
        for (int k = 5; k < D; k++) begin
            chk("R9", "no early expiry", tmr_expire_o, 0);
            @(negedge clk);
        end
        chk("R9", "still armed before D", tmr_armed_o, 1);
        @(negedge clk);                        // after E8
        chk("R10", "expire at D", tmr_expire_o, 1);
        chk("R10", "disarmed at expiry", tmr_armed_o, 0);
        @(negedge clk);
        chk("R10", "expire single cycle", tmr_expire_o, 0);
        repeat (2) @(negedge clk);

        // R6: drain of a full CQ restarts a running timer
        do_write(BASE + 16'd4, 32'd3);         // q0 head 3 (tail 2, size 4 -> full)
        repeat (D + 2) @(negedge clk);
        do_write(BASE, 32'd0);                 // arm at E0
        repeat (2) @(negedge clk);
        do_write(BASE + 16'd4, 32'd1);         // full drain at E3, rearm
        for (int k = 1; k < D; k++) begin
            chk("R6", "rearmed no expiry", tmr_expire_o, 0);
            @(negedge clk);
        end
        chk("R6", "armed after restart", tmr_armed_o, 1);
        @(negedge clk);
        chk("R6", "expire after restart", tmr_expire_o, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule